// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a serial peripheral master that a processor drives through six word-aligned registers. Software sets the frame width, the clock polarity and phase, and two divider factors. It then enables the port and writes frames into an eight-entry transmit queue. A shift engine sends each queued frame on MOSI, most significant bit first, and drives frame select low while it does so. For every frame it sends, it captures exactly one frame into an eight-entry receive queue, which software empties by reading the data register.

Software can poll a status register, or it can enable three interrupt sources, which are merged onto one request line:
- a receive queue that is at least half full;
- a transmit queue that is at most half full;
- a receive overrun.

An internal loopback path joins the outgoing line to the receive shifter, so the port can test itself with no external device. Serial bit timing comes from a separate divider stage, which sits between the shift engine and the system clock.

Top module: `spi_port`

## Requirements
- R1: After reset, the status register (offset 0x0C) reads 0x0003, the interrupt status (offset 0x14) reads 0, SCLK is 0, frame select is high and `irq` is low.
- R2: Control 0 (offset 0x00, 16 bits), control 1 (offset 0x04, bits 6:0) and the prescale (offset 0x10, 8 bits) read back what was written. Byte enable bit 0 guards bits 7:0 and byte enable bit 1 guards bits 15:8.
- R3: With loopback on, each frame of 4 to 16 bits returns unchanged, in all four clock modes, and produces exactly one received frame. Control 1 uses these bits: 4 port enable, 3 loopback, 2 overrun interrupt enable, 1 TX interrupt enable, 0 RX interrupt enable.
- R4: Control 0 sets the serial format. Bits 3:0 hold the frame width minus one, and values below 3 mean 4 bits. Bit 7 is the clock polarity and bit 6 the phase. Bits are sent MSB first. With phase 0 the receiver samples on leading edges, with phase 1 on trailing edges. A frame has twice its width in SCLK edges, and SCLK rests at the polarity level.
- R5: Without loopback the receiver shifts in MISO. With loopback, MISO has no effect on the received data.
- R6: Each queue holds 8 frames, and a data write to a full transmit queue is dropped. Status bits are: 0 TX empty, 1 TX not full, 2 RX not empty, 3 RX full, 4 busy. Busy means a frame is in flight or the TX queue holds data.
- R7: A frame that completes while the receive queue is full is dropped, and the queue contents stay unchanged. The overrun flag (interrupt status bit 2) is set, and any write to offset 0x14 clears it.
- R8: Interrupt status bit 0 reports 4 or more frames in the RX queue. Bit 1 reports 4 or fewer frames in the TX queue. Each bit is masked by its enable, and `irq` is the OR of the three masked bits.
- R9: SCLK toggles every (P/2)·(R+1) clock cycles. P is the prescale, with values below 2 treated as 2, and R is control 0 bits 15:8.
- R10: A data read from an empty receive queue returns 0.
- R11: While port enable is clear, no frame starts, frame select stays high and queued data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register; must be word aligned |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the RX queue at the data offset |
| bus_be | input | 2 | Byte enables for register writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Merged interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fss_n | output | 1 | Active-low frame select |

## Verification
The bench keeps the default parameters: eight-entry queues and a five-bit address. It sweeps every frame width from 4 to 16 in all four clock modes at the fastest divider setting, where SCLK toggles every cycle. One frame is also run at a slow setting of six cycles per half bit, so both divider counters wrap. An eight-entry queue can be filled, overrun and drained within a few hundred cycles, so every level at which the interrupt thresholds change can be reached directly.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int REG_W = 16;

    typedef enum logic [2:0] {
        IDX_CTL0 = 3'd0,
        IDX_CTL1 = 3'd1,
        IDX_DATA = 3'd2,
        IDX_STAT = 3'd3,
        IDX_PRE  = 3'd4,
        IDX_INT  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [7:0] rate;
        logic       cpol;
        logic       cpha;
        logic [1:0] fmt;
        logic [3:0] size_m1;
    } ctl0_t;

    typedef struct packed {
        logic sod;
        logic slave;
        logic en;
        logic loop;
        logic ovr_ie;
        logic tx_ie;
        logic rx_ie;
    } ctl1_t;

    typedef struct packed {
        ctl0_t      c0;
        ctl1_t      c1;
        logic [7:0] pre;
        logic       ovr;
    } regs_t;

endpackage

// File: rtl/spi_port_fifo.sv
module spi_port_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  do_push, do_pop;

    assign full    = (s_q.cnt == CNT_W'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign count   = s_q.cnt;
    assign rdata   = s_q.mem[s_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp = (s_q.wp == PTR_W'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop) begin
            s_d.rp = (s_q.rp == PTR_W'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int HP_W = PRE_W - 1;

    typedef struct packed {
        logic [HP_W-1:0]   pcnt;
        logic [RATE_W-1:0] rcnt;
    } div_t;

    div_t            s_d, s_q;
    logic [HP_W-1:0] half;
    logic            pre_wrap;

    assign half     = (pre[PRE_W-1:1] == '0) ? HP_W'(1) : pre[PRE_W-1:1];
    assign pre_wrap = (s_q.pcnt == half - 1'b1);
    assign tick     = run && pre_wrap && (s_q.rcnt == rate);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d = '0;
        end else if (pre_wrap) begin
            s_d.pcnt = '0;
            s_d.rcnt = (s_q.rcnt == rate) ? '0 : s_q.rcnt + 1'b1;
        end else begin
            s_d.pcnt = s_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               loop,
    input  logic [3:0]         size_m1,
    input  logic               tx_avail,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               tick,
    input  logic               miso,
    output logic               take,
    output logic               active,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               sclk,
    output logic               mosi,
    output logic               fss_n
);
    localparam int NB_W = $clog2(FRAME_W + 1);
    localparam int E_W  = NB_W + 1;

    typedef struct packed {
        logic               active;
        logic               sclk;
        logic [E_W-1:0]     edges;
        logic [FRAME_W-1:0] tx_sr;
        logic [FRAME_W-1:0] rx_sr;
    } sh_t;

    sh_t               s_d, s_q;
    logic [NB_W-1:0]   nbits;
    logic [E_W-1:0]    last_edge;
    logic              rx_in, lead, samp;
    logic [FRAME_W-1:0] mask;

    assign nbits     = (size_m1 < 4'd3) ? NB_W'(4) : NB_W'(size_m1) + 1'b1;
    assign last_edge = {nbits, 1'b0} - 1'b1;
    assign mask      = {FRAME_W{1'b1}} >> (NB_W'(FRAME_W) - nbits);
    assign mosi      = s_q.tx_sr[FRAME_W-1];
    assign rx_in     = loop ? mosi : miso;
    assign lead      = ~s_q.edges[0];
    assign samp      = cpha ? ~lead : lead;
    assign take      = enable && !s_q.active && tx_avail;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!enable) begin
            s_d.active = 1'b0;
            s_d.sclk   = cpol;
            s_d.edges  = '0;
        end else if (!s_q.active) begin
            s_d.sclk = cpol;
            if (tx_avail) begin
                s_d.active = 1'b1;
                s_d.edges  = '0;
                s_d.tx_sr  = tx_word << (NB_W'(FRAME_W) - nbits);
                s_d.rx_sr  = '0;
            end
        end else if (tick) begin
            s_d.sclk  = ~s_q.sclk;
            s_d.edges = s_q.edges + 1'b1;
            if (samp) begin
                s_d.rx_sr = {s_q.rx_sr[FRAME_W-2:0], rx_in};
            end else if (s_q.edges != '0 && s_q.edges != last_edge) begin
                s_d.tx_sr = {s_q.tx_sr[FRAME_W-2:0], 1'b0};
            end
            if (s_q.edges == last_edge) begin
                s_d.active = 1'b0;
                done       = 1'b1;
            end
        end
        rx_word = s_d.rx_sr & mask;
    end

    assign active = s_q.active;
    assign sclk   = s_q.sclk;
    assign fss_n  = ~s_q.active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              fss_n
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int THRESH = FIFO_DEPTH / 2;

    regs_t            r_d, r_q;
    reg_idx_e         idx;
    logic             hit, wr_hit, rd_hit;
    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [REG_W-1:0] tx_head, rx_head, rx_word;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tick, active, frame_done;
    logic             rx_req, tx_req;
    logic [2:0]       int_stat;
    logic [4:0]       status;

    assign hit    = (bus_addr[1:0] == 2'b00);
    assign idx    = reg_idx_e'(bus_addr[ADDR_W-1:2]);
    assign wr_hit = bus_wr && hit;
    assign rd_hit = bus_rd && hit;

    assign tx_push = wr_hit && (idx == IDX_DATA);
    assign rx_pop  = rd_hit && (idx == IDX_DATA);
    assign rx_push = frame_done;

    spi_port_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spi_port_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spi_port_clkdiv #(.PRE_W(8), .RATE_W(8)) u_div (
        .clk(clk), .rst_n(rst_n), .run(active),
        .pre(r_q.pre), .rate(r_q.c0.rate), .tick(tick)
    );

    spi_port_shifter #(.FRAME_W(REG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(r_q.c1.en),
        .cpol(r_q.c0.cpol), .cpha(r_q.c0.cpha), .loop(r_q.c1.loop),
        .size_m1(r_q.c0.size_m1), .tx_avail(!tx_empty), .tx_word(tx_head),
        .tick(tick), .miso(miso), .take(tx_pop), .active(active),
        .done(frame_done), .rx_word(rx_word), .sclk(sclk),
        .mosi(mosi), .fss_n(fss_n)
    );

    assign rx_req   = (rx_cnt >= CNT_W'(THRESH));
    assign tx_req   = (tx_cnt <= CNT_W'(THRESH));
    assign int_stat = {r_q.ovr & r_q.c1.ovr_ie,
                       tx_req  & r_q.c1.tx_ie,
                       rx_req  & r_q.c1.rx_ie};
    assign irq      = |int_stat;
    assign status   = {active | ~tx_empty, rx_full, ~rx_empty, ~tx_full, tx_empty};

    always_comb begin
        r_d = r_q;
        if (wr_hit) begin
            unique case (idx)
                IDX_CTL0: r_d.c0 = ctl0_t'({bus_be[1] ? bus_wdata[15:8] : r_q.c0[15:8],
                                            bus_be[0] ? bus_wdata[7:0]  : r_q.c0[7:0]});
                IDX_CTL1: if (bus_be[0]) r_d.c1 = ctl1_t'(bus_wdata[6:0]);
                IDX_PRE:  if (bus_be[0]) r_d.pre = bus_wdata[7:0];
                IDX_INT:  r_d.ovr = 1'b0;
                default:  ;
            endcase
        end
        if (frame_done && rx_full) r_d.ovr = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (idx)
                IDX_CTL0: bus_rdata = r_q.c0;
                IDX_CTL1: bus_rdata = REG_W'(r_q.c1);
                IDX_DATA: bus_rdata = rx_empty ? '0 : rx_head;
                IDX_STAT: bus_rdata = REG_W'(status);
                IDX_PRE:  bus_rdata = REG_W'(r_q.pre);
                IDX_INT:  bus_rdata = REG_W'(int_stat);
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sclk,
    input logic                       fss_n,
    input logic                       cpol,
    input logic                       port_en,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       done,
    input logic                       rx_full,
    input logic                       rx_pop,
    input logic                       ovr,
    input logic                       irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int TH = DEPTH / 2;

    p_rest_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fss_n) && $stable(cpol)) |-> (sclk == cpol));

    p_start_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fss_n) |-> ($past(tx_cnt) != '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    p_full_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !rx_pop) |=> $stable(rx_cnt));

    p_overrun_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full) |=> ovr);

    p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt < CW'(TH) && tx_cnt > CW'(TH) && !ovr) |-> !irq);

    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> fss_n);

endmodule

bind spi_port spi_port_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fss_n(fss_n),
    .cpol(r_q.c0.cpol), .port_en(r_q.c1.en), .tx_cnt(tx_cnt),
    .rx_cnt(rx_cnt), .done(frame_done), .rx_full(rx_full),
    .rx_pop(rx_pop), .ovr(r_q.ovr), .irq(irq)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, sclk, mosi, fss_n;
    logic        miso = 1'b0;

    int checks = 0, errors = 0, cyc = 0;

    // serial monitor state
    logic        prev_sclk = 1'b0, prev_fss = 1'b1;
    logic        m_cpol = 1'b0, m_cpha = 1'b0;
    logic [15:0] mon = '0;
    int          mon_edges = 0, ivl = 0, exp_ivl = 1, ivl_bad = 0, fss_falls = 0;

    spi_port u_spi_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .fss_n(fss_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (prev_fss && !fss_n) begin
            mon = '0;
            mon_edges = 0;
            fss_falls = fss_falls + 1;
        end else if (sclk != prev_sclk && (!fss_n || !prev_fss)) begin
            if (mon_edges != 0 && ivl != exp_ivl) ivl_bad = ivl_bad + 1;
            if (m_cpha ? (sclk == m_cpol) : (sclk != m_cpol)) mon = {mon[14:0], mosi};
            mon_edges = mon_edges + 1;
            ivl = 1;
        end else begin
            ivl = ivl + 1;
        end
        prev_sclk = sclk;
        prev_fss  = fss_n;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = {idx, 2'b00}; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [15:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'b00}; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        int guard;
        guard = 0;
        s = 16'h0010;
        while (s[4] && guard < 3000) begin
            rd(3'd3, s);
            guard = guard + 1;
        end
    endtask

    initial begin
        logic [15:0] v, exp_v, msk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd3, v); chk("R1 status", v, 16'h0003);
        rd(3'd5, v); chk("R1 int status", v, 16'h0000);
        chk("R1 sclk/fss/irq", {13'b0, sclk, fss_n, irq}, 16'h0002);
        // R10 empty read
        rd(3'd2, v); chk("R10 empty data read", v, 16'h0000);

        // R2 register readback and byte lanes
        wr(3'd0, 16'hA5C7, 2'b11); rd(3'd0, v); chk("R2 ctl0", v, 16'hA5C7);
        wr(3'd0, 16'h33FF, 2'b01); rd(3'd0, v); chk("R2 ctl0 low lane", v, 16'hA5FF);
        wr(3'd0, 16'h5A00, 2'b10); rd(3'd0, v); chk("R2 ctl0 high lane", v, 16'h5AFF);
        wr(3'd1, 16'h0066, 2'b01); rd(3'd1, v); chk("R2 ctl1", v, 16'h0066);
        wr(3'd1, 16'h0000, 2'b01);
        wr(3'd4, 16'h00B6, 2'b01); rd(3'd4, v); chk("R2 prescale", v, 16'h00B6);
        wr(3'd4, 16'h0002, 2'b11);

        // R3 R4 R5 sweep: all modes, all widths, loopback with MISO held
        for (int mode = 0; mode < 4; mode++) begin
            for (int dss = 3; dss < 16; dss++) begin
                m_cpol = mode[1]; m_cpha = mode[0];
                miso = ~mode[0];
                exp_ivl = 1;
                msk = 16'hFFFF >> (15 - dss);
                exp_v = (16'h9C3A ^ (16'(dss) * 16'h0B17) ^ 16'(mode << 5)) & msk;
                wr(3'd0, {8'h00, mode[1], mode[0], 2'b00, 4'(dss)}, 2'b11);
                wr(3'd1, 16'h0018, 2'b01);
                wr(3'd2, exp_v, 2'b11);
                wait_idle();
                rd(3'd2, v); chk("R3 loopback word", v, exp_v);
                rd(3'd3, v); chk("R3 one frame per frame", v, 16'h0003);
                chk("R4 msb-first mosi", mon & msk, exp_v);
                chk("R4 edge count", 16'(mon_edges), 16'(2 * (dss + 1)));
                chk("R4 rest level", {15'b0, sclk}, {15'b0, m_cpol});
            end
        end
        chk("R9 fast interval", 16'(ivl_bad), 16'h0000);

        // R4 width below minimum acts as 4 bits
        m_cpol = 1'b0; m_cpha = 1'b0;
        wr(3'd0, 16'h0001, 2'b11);
        wr(3'd2, 16'hFFFF, 2'b11);
        wait_idle();
        rd(3'd2, v); chk("R4 short width clamps", v, 16'h000F);
        chk("R4 short width edges", 16'(mon_edges), 16'd8);

        // R5 external MISO without loopback
        wr(3'd0, 16'h0007, 2'b11);
        wr(3'd1, 16'h0010, 2'b01);
        miso = 1'b1;
        wr(3'd2, 16'h005A, 2'b11); wait_idle();
        rd(3'd2, v); chk("R5 miso ones", v, 16'h00FF);
        miso = 1'b0;
        wr(3'd2, 16'h00A5, 2'b11); wait_idle();
        rd(3'd2, v); chk("R5 miso zeros", v, 16'h0000);

        // R6 R11 fill while disabled
        wr(3'd1, 16'h0008, 2'b01);
        for (int i = 0; i < 9; i++) wr(3'd2, 16'(16'h10 + i), 2'b11);
        rd(3'd3, v); chk("R6 full tx status", v, 16'h0010);
        begin
            int falls0;
            falls0 = fss_falls;
            repeat (40) @(negedge clk);
            chk("R11 no frame while disabled", 16'(fss_falls - falls0), 16'h0000);
        end
        chk("R11 fss high", {15'b0, fss_n}, 16'h0001);
        rd(3'd3, v); chk("R11 queue kept", v, 16'h0010);

        wr(3'd1, 16'h001F, 2'b01);
        wait_idle();
        rd(3'd3, v); chk("R6 rx full status", v, 16'h000F);
        rd(3'd5, v); chk("R8 both requests", v, 16'h0003);
        chk("R8 irq high", {15'b0, irq}, 16'h0001);

        // R7 overrun
        wr(3'd2, 16'h0055, 2'b11);
        wait_idle();
        rd(3'd5, v); chk("R7 overrun set", v, 16'h0007);
        rd(3'd3, v); chk("R7 rx still full", v, 16'h000F);
        wr(3'd5, 16'h0000, 2'b11);
        rd(3'd5, v); chk("R7 overrun cleared", v, 16'h0003);
        for (int i = 0; i < 4; i++) begin
            rd(3'd2, v); chk("R7 contents kept", v, 16'(16'h10 + i));
        end
        rd(3'd5, v); chk("R8 rx req at four", v, 16'h0003);
        rd(3'd2, v); chk("R7 contents kept", v, 16'h0014);
        rd(3'd5, v); chk("R8 rx req below four", v, 16'h0002);
        for (int i = 5; i < 8; i++) begin
            rd(3'd2, v); chk("R7 contents kept", v, 16'(16'h10 + i));
        end
        rd(3'd2, v); chk("R10 drained read", v, 16'h0000);
        wr(3'd1, 16'h0018, 2'b01);
        rd(3'd5, v); chk("R8 masked", v, 16'h0000);
        chk("R8 irq low", {15'b0, irq}, 16'h0000);

        // R8 tx request threshold: 5 queued is above, 4 queued is at
        wr(3'd1, 16'h000A, 2'b01);
        for (int i = 0; i < 5; i++) wr(3'd2, 16'h0001, 2'b11);
        rd(3'd5, v); chk("R8 tx above half", v, 16'h0000);
        wr(3'd1, 16'h001A, 2'b01);
        wait_idle();
        rd(3'd5, v); chk("R8 tx at or below half", v, 16'h0002);
        for (int i = 0; i < 5; i++) rd(3'd2, v);
        wr(3'd1, 16'h0018, 2'b01);

        // R9 slow divider: prescale 4, rate 2 -> 6 cycles per half bit
        ivl_bad = 0;
        exp_ivl = 6;
        wr(3'd4, 16'h0004, 2'b11);
        wr(3'd0, 16'h0203, 2'b11);
        wr(3'd2, 16'h0009, 2'b11);
        wait_idle();
        rd(3'd2, v); chk("R9 slow frame data", v, 16'h0009);
        chk("R9 half period", 16'(ivl_bad), 16'h0000);
        chk("R9 slow edge count", 16'(mon_edges), 16'd8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule